// File: doc/BRIEF.md
# Program Counter Branch Target Unit

This block works out where an 8-bit microcontroller core goes next, given code addresses of 16 bits. Each request gives it the address of the current instruction, the length of that instruction, an operation class and the operand bytes. It returns the fall-through address, meaning the address of the following instruction. It also returns the branch target that the class calls for and, for code-table reads, the code-memory address to fetch.

There are three jump formats. A short relative jump adds a signed byte to the fall-through address. A block-local jump keeps the top five bits of the fall-through address and takes the low eleven bits from the opcode and one operand byte. A long jump carries a full address in two operand bytes. A table read adds the zero-extended accumulator to one of two bases: the data pointer or the fall-through address.

The unit does not fetch opcodes, decode instructions or evaluate branch conditions. The core issues a one-cycle strobe and reads the registered results one cycle later.

Top module: `pc_target_unit`

## Requirements
- R1: While reset is held, and until the first request after it, all address outputs read 0000h and outValid is low.
- R2: outValid is high in exactly the cycle after a cycle with reqValid high, and low after any cycle with reqValid low.
- R3: fallThru equals curPc + instLen, wrapped modulo 2^16, for instLen of 1, 2 or 3.
- R4: With opClass 00 (relative), branchTarget equals fallThru plus operand1 sign-extended to 16 bits, wrapping modulo 2^16. For example, a 2-byte jump at 07FEh with operand1 FEh targets 07FEh.
- R5: With opClass 01 (block-local), branchTarget is {fallThru[15:11], opcode[7:5], operand1}. The page bits come from the fall-through address, so a 2-byte jump at 07FEh selects the block starting at 0800h. Opcode E1h with operand1 06h at 0700h targets 0706h.
- R6: With opClass 10 (long), branchTarget is {operand1, operand2}, with operand1 as the high byte, for any current address.
- R7: With opClass 11 and tableUsePtr = 1, codeAddr equals dataPtr plus accum zero-extended, wrapping modulo 2^16. For example, 4000h with accum 05h gives 4005h.
- R8: With opClass 11 and tableUsePtr = 0, codeAddr equals fallThru plus accum zero-extended. For example, a 1-byte read at 1002h with accum 05h gives 1008h.
- R9: With opClass 11, branchTarget equals fallThru. With opClass 00, 01 or 10, codeAddr is 0000h.
- R10: A cycle with reqValid low leaves fallThru, branchTarget and codeAddr unchanged, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle |
| curPc | input | 16 | Address of the current instruction |
| instLen | input | 2 | Instruction length in bytes (1..3) |
| opClass | input | 2 | 00 relative, 01 block-local, 10 long, 11 table read |
| opcode | input | 8 | First instruction byte |
| operand1 | input | 8 | Second instruction byte |
| operand2 | input | 8 | Third instruction byte |
| accum | input | 8 | Accumulator value for table reads |
| dataPtr | input | 16 | Data pointer base for table reads |
| tableUsePtr | input | 1 | 1 selects dataPtr as the table base, 0 selects fallThru |
| outValid | output | 1 | Results updated this cycle |
| fallThru | output | 16 | Address of the following instruction |
| branchTarget | output | 16 | Jump destination |
| codeAddr | output | 16 | Table-read address |

## Verification
Every cycle, the assertions check the strobe-to-valid timing, the hold of all outputs on idle cycles, and the fall-through sum. They also check the long-jump byte order, that a block-local target shares its page with the fall-through address, and that codeAddr is zero for jump classes. Only the bench's sweeps can show the exact value of each format. These sweeps cover every displacement, every block-local high-bit pattern, and every accumulator value against both table bases. They include bases next to FFFFh, where the addresses wrap, and requests that cross a 2K boundary.

// File: rtl/pctu_pkg.sv
package pctu_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    CLS_REL   = 2'b00,
    CLS_BLOCK = 2'b01,
    CLS_LONG  = 2'b10,
    CLS_TABLE = 2'b11
  } op_class_e;

  typedef struct packed {
    logic loadEn;
    logic selRel;
    logic selBlock;
    logic selLong;
    logic selTable;
    logic tableFromPtr;
  } pctu_strobe_t;
endpackage

// File: rtl/pctu_ctrl.sv
module pctu_ctrl
  import pctu_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  input  logic [1:0]   opClass,
  input  logic         tableUsePtr,
  output pctu_strobe_t strobe,
  output logic         outValid
);
  op_class_e cls;

  always_comb begin
    cls = op_class_e'(opClass);
    strobe = '0;
    strobe.loadEn = reqValid;
    unique case (cls)
      CLS_REL:   strobe.selRel   = 1'b1;
      CLS_BLOCK: strobe.selBlock = 1'b1;
      CLS_LONG:  strobe.selLong  = 1'b1;
      CLS_TABLE: strobe.selTable = 1'b1;
      default:   strobe.selRel   = 1'b1;
    endcase
    strobe.tableFromPtr = tableUsePtr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= reqValid;
  end
endmodule

// File: rtl/pctu_datapath.sv
module pctu_datapath
  import pctu_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W,
  parameter int PAGE_BITS = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pctu_strobe_t  strobe,
  input  logic [AW-1:0] curPc,
  input  logic [1:0]    instLen,
  input  logic [BW-1:0] opcode,
  input  logic [BW-1:0] operand1,
  input  logic [BW-1:0] operand2,
  input  logic [BW-1:0] accum,
  input  logic [AW-1:0] dataPtr,
  output logic [AW-1:0] fallThru,
  output logic [AW-1:0] branchTarget,
  output logic [AW-1:0] codeAddr
);
  localparam int HI_FROM_OP = PAGE_BITS - BW;
  localparam int EXT_W = AW - BW;

  logic [AW-1:0] nextPc, relTgt, blockTgt, longTgt, tblBase, tblAddr;
  logic [AW-1:0] tgtMux, addrMux;

  always_comb begin
    nextPc   = curPc + AW'(instLen);
    relTgt   = nextPc + {{EXT_W{operand1[BW-1]}}, operand1};
    blockTgt = {nextPc[AW-1:PAGE_BITS], opcode[BW-1 -: HI_FROM_OP], operand1};
    longTgt  = AW'({operand1, operand2});
    tblBase  = strobe.tableFromPtr ? dataPtr : nextPc;
    tblAddr  = tblBase + {{EXT_W{1'b0}}, accum};
    tgtMux   = nextPc;
    addrMux  = '0;
    if (strobe.selRel)   tgtMux = relTgt;
    if (strobe.selBlock) tgtMux = blockTgt;
    if (strobe.selLong)  tgtMux = longTgt;
    if (strobe.selTable) addrMux = tblAddr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fallThru     <= '0;
      branchTarget <= '0;
      codeAddr     <= '0;
    end else if (strobe.loadEn) begin
      fallThru     <= nextPc;
      branchTarget <= tgtMux;
      codeAddr     <= addrMux;
    end
  end
endmodule

// File: rtl/pc_target_unit.sv
module pc_target_unit
  import pctu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic [15:0] curPc,
  input  logic [1:0]  instLen,
  input  logic [1:0]  opClass,
  input  logic [7:0]  opcode,
  input  logic [7:0]  operand1,
  input  logic [7:0]  operand2,
  input  logic [7:0]  accum,
  input  logic [15:0] dataPtr,
  input  logic        tableUsePtr,
  output logic        outValid,
  output logic [15:0] fallThru,
  output logic [15:0] branchTarget,
  output logic [15:0] codeAddr
);
  pctu_strobe_t strobe;

  pctu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .opClass(opClass),
    .tableUsePtr(tableUsePtr), .strobe(strobe), .outValid(outValid)
  );

  pctu_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .curPc(curPc),
    .instLen(instLen), .opcode(opcode), .operand1(operand1),
    .operand2(operand2), .accum(accum), .dataPtr(dataPtr),
    .fallThru(fallThru), .branchTarget(branchTarget), .codeAddr(codeAddr)
  );
endmodule

// File: rtl/pctu_chk.sv
module pctu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reqValid,
  input logic [15:0] curPc,
  input logic [1:0]  instLen,
  input logic [1:0]  opClass,
  input logic [7:0]  operand1,
  input logic [7:0]  operand2,
  input logic        outValid,
  input logic [15:0] fallThru,
  input logic [15:0] branchTarget,
  input logic [15:0] codeAddr
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> outValid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !outValid);
  // R3
  fall_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> fallThru == $past(curPc) + 16'($past(instLen)));
  // R5
  block_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && opClass == 2'b01) |=> branchTarget[15:11] == fallThru[15:11]);
  // R6
  long_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && opClass == 2'b10) |=> branchTarget == {$past(operand1), $past(operand2)});
  // R9
  jump_noaddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && opClass != 2'b11) |=> codeAddr == 16'h0000);
  // R9
  table_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && opClass == 2'b11) |=> branchTarget == fallThru);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> ($stable(fallThru) && $stable(branchTarget) && $stable(codeAddr)));
endmodule

bind pc_target_unit pctu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .curPc(curPc),
  .instLen(instLen), .opClass(opClass), .operand1(operand1),
  .operand2(operand2), .outValid(outValid), .fallThru(fallThru),
  .branchTarget(branchTarget), .codeAddr(codeAddr)
);

// File: tb/sim_pc_target_unit.sv
module sim_pc_target_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] curPc = '0;
  logic [1:0]  instLen = 2'd1;
  logic [1:0]  opClass = '0;
  logic [7:0]  opcode = '0, operand1 = '0, operand2 = '0, accum = '0;
  logic [15:0] dataPtr = '0;
  logic        tableUsePtr = 1'b0;
  logic        outValid;
  logic [15:0] fallThru, branchTarget, codeAddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] codeMem [0:7];

  always #10 clk = ~clk;

  pc_target_unit u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .curPc(curPc),
    .instLen(instLen), .opClass(opClass), .opcode(opcode),
    .operand1(operand1), .operand2(operand2), .accum(accum),
    .dataPtr(dataPtr), .tableUsePtr(tableUsePtr), .outValid(outValid),
    .fallThru(fallThru), .branchTarget(branchTarget), .codeAddr(codeAddr)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive a request at a falling edge, sample results at the next falling edge
  task automatic issue(input logic [15:0] pc, input logic [1:0] len, input logic [1:0] cls,
                       input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2,
                       input logic [7:0] a, input logic [15:0] dp, input logic usePtr);
    @(negedge clk);
    curPc = pc; instLen = len; opClass = cls; opcode = op;
    operand1 = b1; operand2 = b2; accum = a; dataPtr = dp; tableUsePtr = usePtr;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] pc, input logic [1:0] len);
    return pc + {14'd0, len};
  endfunction

  initial begin
    #3_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] exp;
    logic [15:0] pcs [0:3];
    pcs[0] = 16'h0000; pcs[1] = 16'h07FE; pcs[2] = 16'h8000; pcs[3] = 16'hFFFE;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outValid", {15'd0, outValid}, 16'h0);
    check("R1 fallThru", fallThru, 16'h0);
    check("R1 branchTarget", branchTarget, 16'h0);
    check("R1 codeAddr", codeAddr, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {15'd0, outValid}, 16'h0);

    // R4 jump-to-self from a tiny code array: 80h FEh at 07FEh
    codeMem[0] = 8'h80; codeMem[1] = 8'hFE;
    codeMem[2] = 8'hE1; codeMem[3] = 8'h06;
    issue(16'h07FE, 2'd2, 2'b00, codeMem[0], codeMem[1], 8'h00, 8'h00, 16'h0, 1'b0);
    check("R4 self jump", branchTarget, 16'h07FE);
    check("R2 outValid high", {15'd0, outValid}, 16'h1);
    check("R9 rel codeAddr", codeAddr, 16'h0);
    @(negedge clk);
    check("R2 outValid low", {15'd0, outValid}, 16'h0);

    // R5 block-local example E1h 06h at 0700h
    issue(16'h0700, 2'd2, 2'b01, codeMem[2], codeMem[3], 8'h00, 8'h00, 16'h0, 1'b0);
    check("R5 example", branchTarget, 16'h0706);

    // R7 / R8 examples
    issue(16'h0000, 2'd1, 2'b11, 8'h93, 8'h00, 8'h00, 8'h05, 16'h4000, 1'b1);
    check("R7 example", codeAddr, 16'h4005);
    issue(16'h1002, 2'd1, 2'b11, 8'h83, 8'h00, 8'h00, 8'h05, 16'h4000, 1'b0);
    check("R8 example", codeAddr, 16'h1008);
    check("R9 table branchTarget", branchTarget, 16'h1003);

    // R3 / R4 sweep of every displacement at several addresses and lengths
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < 256; d++) begin
        logic [1:0] len;
        len = 2'(1 + (d % 3));
        issue(pcs[p], len, 2'b00, 8'h80, 8'(d), 8'h00, 8'h00, 16'h0, 1'b0);
        exp = nxt(pcs[p], len);
        check("R3 fallThru", fallThru, exp);
        exp = exp + {{8{d[7]}}, 8'(d)};
        check("R4 rel target", branchTarget, exp);
      end
    end

    // R5 sweep of high-bit patterns and low bytes across page edges
    for (int p = 0; p < 4; p++) begin
      for (int h = 0; h < 8; h++) begin
        for (int lo = 0; lo < 256; lo += 17) begin
          logic [7:0] op;
          op = {3'(h), 5'b00001};
          issue(pcs[p], 2'd2, 2'b01, op, 8'(lo), 8'h00, 8'h00, 16'h0, 1'b0);
          exp = nxt(pcs[p], 2'd2);
          exp = {exp[15:11], 3'(h), 8'(lo)};
          check("R5 block target", branchTarget, exp);
          check("R9 block codeAddr", codeAddr, 16'h0);
        end
      end
    end

    // R6 long jump over many byte pairs
    for (int hi = 0; hi < 256; hi += 5) begin
      for (int lo = 0; lo < 256; lo += 51) begin
        issue(pcs[hi % 4], 2'd3, 2'b10, 8'h02, 8'(hi), 8'(lo), 8'h00, 16'h0, 1'b0);
        check("R6 long target", branchTarget, {8'(hi), 8'(lo)});
        check("R3 long fallThru", fallThru, nxt(pcs[hi % 4], 2'd3));
      end
    end

    // R7 / R8 every accumulator value against both bases, including wrap
    for (int a = 0; a < 256; a++) begin
      issue(16'h0000, 2'd1, 2'b11, 8'h93, 8'h00, 8'h00, 8'(a), 16'hFFC0, 1'b1);
      check("R7 pointer table", codeAddr, 16'hFFC0 + {8'd0, 8'(a)});
      issue(16'hFFF0, 2'd1, 2'b11, 8'h83, 8'h00, 8'h00, 8'(a), 16'h1234, 1'b0);
      check("R8 pc table", codeAddr, 16'hFFF1 + {8'd0, 8'(a)});
      check("R9 table target", branchTarget, 16'hFFF1);
    end

    // R10 inputs move while reqValid is low
    issue(16'h2345, 2'd3, 2'b10, 8'h02, 8'hAB, 8'hCD, 8'h00, 16'h0, 1'b0);
    @(negedge clk);
    curPc = 16'h9999; opClass = 2'b11; accum = 8'h77; dataPtr = 16'h5555;
    tableUsePtr = 1'b1; operand1 = 8'h11; operand2 = 8'h22;
    repeat (2) @(negedge clk);
    check("R10 hold fallThru", fallThru, 16'h2348);
    check("R10 hold branchTarget", branchTarget, 16'hABCD);
    check("R10 hold codeAddr", codeAddr, 16'h0);
    check("R2 idle valid", {15'd0, outValid}, 16'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule